// File: doc/BRIEF.md
# Reference-Compare Interval Timer

This block is a 16-bit up-counter behind a small register bus. Its control word holds an enable bit, a clock-source selector, an 8-bit prescale value, a restart-on-match bit and an interrupt enable. The counter steps once per prescaled tick. The tick comes from the system clock divided by the prescale value plus one, and optionally by a further 16. When the counter arrives at the programmed match value, a sticky flag is raised. If the interrupt enable is set, that flag drives the interrupt line.

Software programs the match value, sets the control word and waits for the interrupt. It then clears the flag by writing a one to it. The counter can also be read, or loaded directly, at any time. Every write to the control word or to the match value restarts both the counter and the prescaler from the new settings. Turning the enable bit off clears the control word and the match value.

Top module: `refcmp_timer`

## Requirements
- R1: After reset, the control word (offset 0x00), match value (0x04), capture word (0x08), counter (0x0C) and flag byte (0x11) all read zero, and `irq` is low.
- R2: With enable (control bit 0) set and clock source (control bits 2:1) equal to 1, the counter steps by one every P+1 clock cycles, where P is control bits 15:8. The first step comes P+1 cycles after the control write.
- R3: With clock source 2, the step period becomes 16*(P+1) cycles.
- R4: The counter holds its value while the enable bit is 0, or while the clock source is 0 or 3.
- R5: When a step brings the counter to the match value, flag bit 1 at offset 0x11 is set and stays set. Flag bit 0 always reads 0.
- R6: With restart (control bit 3) set, the step after the match value returns the counter to 0, giving a period of match+1 steps. With restart clear, the counter keeps counting past the match value.
- R7: Writing to offset 0x11 clears each flag bit whose written bit is 1. Bits written as 0 are left unchanged.
- R8: `irq` is high exactly while control bit 4 and flag bit 1 are both set. It follows register writes with no extra delay.
- R9: A control write that takes the enable bit from 1 to 0 leaves both the control word and the match value at zero. A control write that keeps the enable bit at 1 does not alter the match value.
- R10: Any write to the control word or to the match value sets the counter to 0 and restarts the prescaler.
- R11: A write to offset 0x0C loads the counter. Counting continues from the loaded value, and the counter wraps from 0xFFFF to 0.
- R12: Offset 0x08 stores and returns the written halfword. Reads of an unmapped offset return 0, and writes to an unmapped offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data (flag writes use bits 1:0) |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Match interrupt |

## Verification
The bench builds the block with its defaults: 16-bit data and counter, 5-bit offsets and a 16-way extra divider stage. It keeps prescale values at 3 or below and match values at 30 or below. With those limits, the divide-by-16 path, several restart wraps and the flag/interrupt interplay all occur within a few hundred cycles per trial. Directed cases cover the 0xFFFF wrap, the disable-clears path, counter loads, idle clock sources and unmapped offsets.

// File: rtl/rct_pkg.sv
package rct_pkg;

   typedef enum logic [1:0] {
      SRC_STOP  = 2'd0,
      SRC_SYS   = 2'd1,
      SRC_SYS16 = 2'd2,
      SRC_EXT   = 2'd3
   } clk_src_e;

   // byte offsets decoded by the register block
   localparam int OFS_MODE = 'h00;
   localparam int OFS_REF  = 'h04;
   localparam int OFS_CAP  = 'h08;
   localparam int OFS_CNT  = 'h0C;
   localparam int OFS_EVT  = 'h11;

   // control word bit positions
   localparam int MB_EN      = 0;
   localparam int MB_SRC_LO  = 1;
   localparam int MB_RESTART = 3;
   localparam int MB_IE      = 4;
   localparam int MB_PSC_LO  = 8;

   // flag byte bit positions
   localparam int EB_CAP = 0;
   localparam int EB_REF = 1;

endpackage

// File: rtl/rct_prescale.sv
module rct_prescale #(
   parameter int PSC_W    = 8,
   parameter int EXT_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic             use_ext,
   input  logic [PSC_W-1:0] psc_load,
   output logic             tick
);

   logic [PSC_W-1:0] pc_q;
   logic             stage;

   assign stage = run && (pc_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        pc_q <= '0;
      else if (restart || !run || stage) pc_q <= psc_load;
      else                               pc_q <= pc_q - 1'b1;
   end

   generate
      if (EXT_LOG2 > 0) begin : g_ext
         logic [EXT_LOG2-1:0] ext_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                ext_q <= '0;
            else if (restart || !run)  ext_q <= '0;
            else if (stage && use_ext) ext_q <= ext_q + 1'b1;
         end
         assign tick = stage && (!use_ext || (&ext_q));
      end else begin : g_noext
         logic unused_ext;
         assign unused_ext = use_ext;
         assign tick = stage;
      end
   endgenerate

endmodule

// File: rtl/rct_counter.sv
module rct_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             wrap_mode,
   input  logic [CNT_W-1:0] ref_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             hit
);

   logic [CNT_W-1:0] nxt;

   assign nxt = (wrap_mode && (cnt_q == ref_val)) ? '0 : cnt_q + 1'b1;
   assign hit = tick && !clear && !load && (nxt == ref_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (load)  cnt_q <= load_val;
      else if (tick)  cnt_q <= nxt;
   end

endmodule

// File: rtl/rct_regs.sv
module rct_regs
   import rct_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 5,
   localparam int PSC_W = DATA_W - 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic              hit,
   output logic              en,
   output clk_src_e          src,
   output logic              wrap_mode,
   output logic              irq_en,
   output logic [PSC_W-1:0]  psc_next,
   output logic [CNT_W-1:0]  ref_q,
   output logic              ref_flag,
   output logic              ctr_clear,
   output logic              ctr_load,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mode_q, mode_d, cap_q;
   logic wr_mode, wr_ref, wr_cap, wr_cnt, wr_evt, shutdown;

   assign wr_mode  = we && (addr == ADDR_W'(OFS_MODE));
   assign wr_ref   = we && (addr == ADDR_W'(OFS_REF));
   assign wr_cap   = we && (addr == ADDR_W'(OFS_CAP));
   assign wr_cnt   = we && (addr == ADDR_W'(OFS_CNT));
   assign wr_evt   = we && (addr == ADDR_W'(OFS_EVT));
   assign shutdown = wr_mode && mode_q[MB_EN] && !wdata[MB_EN];

   always_comb begin
      mode_d = mode_q;
      if (wr_mode) mode_d = shutdown ? '0 : wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         ref_q    <= '0;
         cap_q    <= '0;
         ref_flag <= 1'b0;
      end else begin
         mode_q <= mode_d;
         if (shutdown)    ref_q <= '0;
         else if (wr_ref) ref_q <= wdata[CNT_W-1:0];
         if (wr_cap) cap_q <= wdata;
         ref_flag <= hit || (ref_flag && !(wr_evt && wdata[EB_REF]));
      end
   end

   assign en        = mode_q[MB_EN];
   assign src       = clk_src_e'(mode_q[MB_SRC_LO +: 2]);
   assign wrap_mode = mode_q[MB_RESTART];
   assign irq_en    = mode_q[MB_IE];
   assign psc_next  = mode_d[MB_PSC_LO +: PSC_W];
   assign ctr_clear = wr_mode || wr_ref;
   assign ctr_load  = wr_cnt;

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(OFS_MODE): rdata = mode_q;
         ADDR_W'(OFS_REF):  rdata = DATA_W'(ref_q);
         ADDR_W'(OFS_CAP):  rdata = cap_q;
         ADDR_W'(OFS_CNT):  rdata = DATA_W'(cnt_q);
         ADDR_W'(OFS_EVT): begin
            rdata[EB_REF] = ref_flag;
            rdata[EB_CAP] = 1'b0;
         end
         default:           rdata = '0;
      endcase
   end

endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
   import rct_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int CNT_W        = 16,
   parameter int ADDR_W       = 5,
   parameter int EXT_DIV_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int PSC_W = DATA_W - 8;

   generate
      if (DATA_W <= 8)                begin : g_bad_data $error("DATA_W must exceed 8"); end
      if (CNT_W > DATA_W)             begin : g_bad_cnt  $error("CNT_W must not exceed DATA_W"); end
      if (ADDR_W < 5)                 begin : g_bad_addr $error("ADDR_W must be at least 5"); end
      if (EXT_DIV_LOG2 < 0 || EXT_DIV_LOG2 > 8) begin : g_bad_ext $error("EXT_DIV_LOG2 out of range"); end
   endgenerate

   logic             en, wrap_mode, irq_en, ref_flag, ctr_clear, ctr_load;
   logic             running, tick, hit;
   clk_src_e         src;
   logic [PSC_W-1:0] psc_next;
   logic [CNT_W-1:0] ref_q, cnt_q;

   rct_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .cnt_q(cnt_q), .hit(hit), .en(en), .src(src), .wrap_mode(wrap_mode),
      .irq_en(irq_en), .psc_next(psc_next), .ref_q(ref_q), .ref_flag(ref_flag),
      .ctr_clear(ctr_clear), .ctr_load(ctr_load), .rdata(bus_rdata)
   );

   assign running = en && ((src == SRC_SYS) || (src == SRC_SYS16));

   rct_prescale #(.PSC_W(PSC_W), .EXT_LOG2(EXT_DIV_LOG2)) u_psc (
      .clk(clk), .rst_n(rst_n), .restart(ctr_clear), .run(running),
      .use_ext(src == SRC_SYS16), .psc_load(psc_next), .tick(tick)
   );

   rct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(ctr_clear), .load(ctr_load),
      .load_val(bus_wdata[CNT_W-1:0]), .tick(tick), .wrap_mode(wrap_mode),
      .ref_val(ref_q), .cnt_q(cnt_q), .hit(hit)
   );

   assign irq = irq_en && ref_flag;

endmodule

// File: rtl/rct_checker.sv
module rct_checker
   import rct_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] mode_q,
   input logic [CNT_W-1:0]  ref_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              ref_flag,
   input logic              tick,
   input logic              running
);

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !we) |=> $stable(cnt_q)); // R4

   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(OFS_MODE) && mode_q[MB_EN] && !wdata[MB_EN])
      |=> (mode_q == '0 && ref_q == '0)); // R9

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (addr == ADDR_W'(OFS_MODE) || addr == ADDR_W'(OFS_REF))) |=> (cnt_q == '0)); // R10

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !we && !(mode_q[MB_RESTART] && cnt_q == ref_q))
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2

   AST_WRAP_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !we && mode_q[MB_RESTART] && cnt_q == ref_q) |=> (cnt_q == '0)); // R6

   AST_W1C_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(OFS_EVT) && wdata[EB_REF] && !tick) |=> !ref_flag); // R7

endmodule

bind refcmp_timer rct_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
   .mode_q(u_regs.mode_q), .ref_q(ref_q), .cnt_q(cnt_q), .ref_flag(ref_flag),
   .tick(tick), .running(running)
);

// File: tb/sim_refcmp_timer.sv
module sim_refcmp_timer;

   localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAP = 5'h08,
                          A_CNT = 5'h0C, A_EVT = 5'h11;

   logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, irq;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   refcmp_timer u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
   endtask

   // counter, flag byte and irq sampled at one instant
   task automatic snap(output logic [15:0] c, output logic [15:0] e, output logic i);
      @(negedge clk);
      bus_addr = A_CNT; #1 c = bus_rdata;
      bus_addr = A_EVT; #1 e = bus_rdata;
      i = irq;
   endtask

   function automatic int exp_cnt(int n, int psc, int src, int rv, bit rs);
      int d = (psc + 1) * ((src == 2) ? 16 : 1);
      int t = n / d;
      return rs ? (t % (rv + 1)) : (t % 65536);
   endfunction

   function automatic bit exp_flag(int n, int psc, int src, int rv);
      int d = (psc + 1) * ((src == 2) ? 16 : 1);
      return (n / d) >= rv;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, c, e;
      logic i;
      int seed;
      seed = $urandom(32'd20240611);
      edges(3);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(A_MODE, v); chk("R1 mode", v, 0);
      rd(A_REF, v);  chk("R1 ref", v, 0);
      rd(A_CAP, v);  chk("R1 cap", v, 0);
      snap(c, e, i);
      chk("R1 cnt", c, 0); chk("R1 flags", e, 0); chk("R1 irq", i, 0);

      // R12 capture storage and unmapped offsets
      wr(A_CAP, 16'hBEEF); rd(A_CAP, v); chk("R12 cap", v, 16'hBEEF);
      wr(5'h06, 16'h1234); rd(5'h06, v); chk("R12 unmapped read", v, 0);
      rd(A_MODE, v); chk("R12 unmapped write mode", v, 0);
      rd(A_REF, v);  chk("R12 unmapped write ref", v, 0);

      // R4 idle clock sources and disabled
      wr(A_REF, 16'd100);
      wr(A_MODE, 16'h0001); edges(20); snap(c, e, i); chk("R4 src0", c, 0);
      wr(A_MODE, 16'h0007); edges(20); snap(c, e, i); chk("R4 src3", c, 0);
      wr(A_MODE, 16'h0002); edges(20); snap(c, e, i); chk("R4 disabled", c, 0);

      // R2 prescale 2 -> period 3
      wr(A_REF, 16'd100);
      wr(A_MODE, 16'h0203); edges(30); snap(c, e, i); chk("R2 div3", c, 10);
      wr(A_MODE, 16'h0003); edges(1);  snap(c, e, i); chk("R2 first step", c, 1);

      // R3 extra divide by 16
      wr(A_MODE, 16'h0005); edges(47); snap(c, e, i); chk("R3 before", c, 2);
      edges(1); snap(c, e, i); chk("R3 div16", c, 3);

      // R5 R6 R8 restart mode with interrupt
      wr(A_MODE, 16'h0000); wr(A_EVT, 16'h0003); wr(A_REF, 16'd5);
      wr(A_MODE, 16'h001B); edges(4); snap(c, e, i);
      chk("R5 no flag yet", e, 0); chk("R8 irq low", i, 0);
      edges(1); snap(c, e, i);
      chk("R5 at ref", c, 5); chk("R5 flag", e, 2); chk("R8 irq high", i, 1);
      edges(1); snap(c, e, i); chk("R6 wrap", c, 0);

      // R6 free-running past ref
      wr(A_MODE, 16'h0000); wr(A_EVT, 16'h0003); wr(A_REF, 16'd5);
      wr(A_MODE, 16'h0013); edges(7); snap(c, e, i);
      chk("R6 past ref", c, 7); chk("R5 flag free", e, 2);

      // R7 write-one-to-clear
      wr(A_EVT, 16'h0001); rd(A_EVT, v); chk("R7 zero bit kept", v, 2);
      wr(A_EVT, 16'h0002); snap(c, e, i);
      chk("R7 cleared", e, 0); chk("R8 irq follows clear", i, 0);

      // R8 enable gating; R9 ref kept while enabled
      wr(A_MODE, 16'h0000); wr(A_EVT, 16'h0003); wr(A_REF, 16'd2);
      wr(A_MODE, 16'h000B); edges(10); snap(c, e, i);
      chk("R8 flag no irq", e, 2); chk("R8 ie off", i, 0);
      wr(A_MODE, 16'h001B); snap(c, e, i); chk("R8 ie on", i, 1);
      rd(A_REF, v); chk("R9 ref kept", v, 2);

      // R9 disable clears
      wr(A_MODE, 16'h0000);
      rd(A_MODE, v); chk("R9 mode cleared", v, 0);
      rd(A_REF, v);  chk("R9 ref cleared", v, 0);

      // R10 ref write restarts
      wr(A_EVT, 16'h0003); wr(A_REF, 16'd1000);
      wr(A_MODE, 16'h0003); edges(20); snap(c, e, i); chk("R10 running", c, 20);
      wr(A_REF, 16'd900); snap(c, e, i); chk("R10 restart", c, 0);
      edges(4); snap(c, e, i); chk("R10 resume", c, 4);

      // R11 counter load and wrap
      wr(A_CNT, 16'h0100); edges(3); snap(c, e, i); chk("R11 load", c, 16'h0103);
      wr(A_CNT, 16'hFFFF); edges(1); snap(c, e, i); chk("R11 wrap", c, 0);

      // randomized trials (R2 R3 R5 R6 R8)
      for (int k = 0; k < 40; k++) begin
         int psc, src, rv, n;
         bit rs, ie, fl;
         psc = $urandom % 4; src = 1 + ($urandom % 2); rv = 1 + ($urandom % 30);
         rs = 1'($urandom % 2); ie = 1'($urandom % 2); n = $urandom % 160;
         wr(A_MODE, 16'h0000); wr(A_EVT, 16'h0003); wr(A_REF, 16'(rv));
         wr(A_MODE, 16'((psc << 8) | (ie << 4) | (rs << 3) | (src << 1) | 1));
         edges(n); snap(c, e, i);
         fl = exp_flag(n, psc, src, rv);
         chk("R2/R3/R6 rand cnt", c, exp_cnt(n, psc, src, rv, rs));
         chk("R5 rand flag", e, fl ? 2 : 0);
         chk("R8 rand irq", i, ie && fl);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule